// File: doc/BRIEF.md
# Programmable Gain Code Register and Tap Decoder

This block is the digital control front end of an amplifier whose gain steps in powers of two. It takes a three-bit gain code and a gain-enable bit. It keeps them in a register that two interchangeable gate inputs control, and it turns the held value into one-hot tap enables for gains of 1, 2, 4, 8 and 16. It also raises a wide-bandwidth flag that switches out part of the compensation when the gain is 8 or higher.

The register passes the code through while both gates are low. As soon as either gate is high it freezes the last value it took. It is built as synchronous sampling on the system clock, so no storage is level-sensitive. The outputs therefore follow the inputs one clock after each edge at which both gates were low.

A build-time cascade option drives a second stage from the same code, so that codes 0 to 7 give an overall gain of 2^code, up to 128. Without cascade, the second stage stays at unity, and codes above the highest tap are clamped to gain 16 and flagged.

Top module: `pga_gain_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, both stages select tap 0 (unity gain), both wide-bandwidth flags are low and the out-of-range flag is low.
- R2: At each clock edge where both gate inputs are low, the enable bit and code are sampled together, and the outputs reflect them from the following cycle.
- R3: At a clock edge where either gate input is high, the held enable bit and code do not change. The two gates act identically, and the held value is released only when both are low.
- R4: With the enable bit low, stage A selects tap 0 whatever the code, stage B selects tap 0, and the out-of-range flag is low.
- R5: Each stage's tap bus is one-hot at all times. Bit i selects gain 2^i, and with enable high, codes 0 to 4 put the one in bit `code` of stage A.
- R6: A stage's wide-bandwidth flag is high exactly when that stage selects tap 3 or tap 4 (gain 8 or 16).
- R7: Without cascade, enabled codes 5 to 7 select tap 4 of stage A and raise the out-of-range flag. Stage B always selects tap 0 in this mode.
- R8: With cascade, stage A selects tap min(code,4). Stage B selects tap code−4 for enabled codes 5 to 7 and tap 0 otherwise, so the sum of the two tap indices equals the code. The out-of-range flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_a_i | input | 1 | Gate input; high freezes the held code |
| gate_b_i | input | 1 | Second gate input, equivalent to gate_a_i |
| gain_en_i | input | 1 | Gain enable; low forces unity gain |
| gain_code_i | input | 3 | Requested gain code |
| tap_a_o | output | 5 | Stage A one-hot tap enables, bit i = gain 2^i |
| wide_bw_a_o | output | 1 | Stage A reduced-compensation flag |
| tap_b_o | output | 5 | Stage B one-hot tap enables |
| wide_bw_b_o | output | 1 | Stage B reduced-compensation flag |
| code_over_o | output | 1 | Enabled code above the highest tap (single-stage only) |

## Verification
The bench builds two copies side by side with the default widths (three-bit code, five taps, wide-bandwidth threshold at tap 3). One has cascade off and the other has it on, and both are driven from the same inputs. The non-cascade copy reaches the clamping of codes 5 to 7 and the out-of-range flag. The cascade copy reaches the split of a code between the two stages and stage B's own flag. All eight codes are swept with enable high and with enable low, and each gate is exercised alone, together with the other, and with one dropped while the other stays high.

// File: rtl/pga_pkg.sv
package pga_pkg;
  localparam int unsigned PGA_CODE_W   = 3;
  localparam int unsigned PGA_NUM_TAPS = 5;
  localparam int unsigned PGA_WIDE_TAP = 3;

  typedef struct packed {
    logic                  en;
    logic [PGA_CODE_W-1:0] code;
  } pga_word_t;
endpackage

// File: rtl/pga_rst_sync.sv
module pga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pga_code_reg.sv
module pga_code_reg
  import pga_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q_n,
  input  logic      gate_a_i,
  input  logic      gate_b_i,
  input  pga_word_t word_i,
  output pga_word_t word_o
);
  pga_word_t word_q, word_d;
  logic      load_en;

  assign load_en = ~(gate_a_i | gate_b_i);

  always_comb begin
    word_d = word_q;
    if (load_en) word_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) word_q <= '0;
    else          word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/pga_tap_decoder.sv
module pga_tap_decoder #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned NUM_TAPS = 5,
  parameter int unsigned WIDE_TAP = 3
) (
  input  logic                en_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic [NUM_TAPS-1:0] tap_o,
  output logic                wide_bw_o,
  output logic                over_o
);
  localparam logic [CODE_W-1:0] TOP_IDX  = CODE_W'(NUM_TAPS - 1);
  localparam logic [CODE_W-1:0] WIDE_IDX = CODE_W'(WIDE_TAP);

  logic [CODE_W-1:0] idx;
  logic              above;

  assign above = code_i > TOP_IDX;

  always_comb begin
    if (!en_i)      idx = '0;
    else if (above) idx = TOP_IDX;
    else            idx = code_i;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_o[i] = (idx == CODE_W'(i));
  end

  assign wide_bw_o = idx >= WIDE_IDX;
  assign over_o    = en_i & above;
endmodule

// File: rtl/pga_gain_ctrl.sv
module pga_gain_ctrl
  import pga_pkg::*;
#(
  parameter int unsigned CODE_W   = PGA_CODE_W,
  parameter int unsigned NUM_TAPS = PGA_NUM_TAPS,
  parameter int unsigned WIDE_TAP = PGA_WIDE_TAP,
  parameter bit          CASCADE  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gate_a_i,
  input  logic                gate_b_i,
  input  logic                gain_en_i,
  input  logic [CODE_W-1:0]   gain_code_i,
  output logic [NUM_TAPS-1:0] tap_a_o,
  output logic                wide_bw_a_o,
  output logic [NUM_TAPS-1:0] tap_b_o,
  output logic                wide_bw_b_o,
  output logic                code_over_o
);
  localparam logic [CODE_W-1:0] SPLIT = CODE_W'(NUM_TAPS - 1);

  logic        rst_q_n;
  pga_word_t   in_word, held;
  logic              en_a, en_b;
  logic [CODE_W-1:0] code_a, code_b;
  logic              over_a, over_b;

  assign in_word.en   = gain_en_i;
  assign in_word.code = gain_code_i;

  pga_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  pga_code_reg u_reg (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .gate_a_i (gate_a_i),
    .gate_b_i (gate_b_i),
    .word_i   (in_word),
    .word_o   (held)
  );

  if (CASCADE) begin : g_cascade
    logic beyond;
    assign beyond = held.code > SPLIT;
    assign en_a   = held.en;
    assign code_a = beyond ? SPLIT : held.code;
    assign en_b   = held.en & beyond;
    assign code_b = beyond ? (held.code - SPLIT) : '0;
  end else begin : g_single
    assign en_a   = held.en;
    assign code_a = held.code;
    assign en_b   = 1'b0;
    assign code_b = '0;
  end

  pga_tap_decoder #(.CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS), .WIDE_TAP(WIDE_TAP)) u_dec_a (
    .en_i      (en_a),
    .code_i    (code_a),
    .tap_o     (tap_a_o),
    .wide_bw_o (wide_bw_a_o),
    .over_o    (over_a)
  );

  pga_tap_decoder #(.CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS), .WIDE_TAP(WIDE_TAP)) u_dec_b (
    .en_i      (en_b),
    .code_i    (code_b),
    .tap_o     (tap_b_o),
    .wide_bw_o (wide_bw_b_o),
    .over_o    (over_b)
  );

  assign code_over_o = CASCADE ? 1'b0 : (over_a | over_b);
endmodule

// File: rtl/pga_gain_ctrl_chk.sv
module pga_gain_ctrl_chk #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned NUM_TAPS = 5,
  parameter int unsigned WIDE_TAP = 3,
  parameter bit          CASCADE  = 1'b0
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                gate_a_i,
  input logic                gate_b_i,
  input logic                gain_en_i,
  input logic [CODE_W-1:0]   gain_code_i,
  input logic [NUM_TAPS-1:0] tap_a_o,
  input logic                wide_bw_a_o,
  input logic [NUM_TAPS-1:0] tap_b_o,
  input logic                wide_bw_b_o,
  input logic                code_over_o
);
  localparam logic [CODE_W-1:0] TOP_IDX = CODE_W'(NUM_TAPS - 1);

  logic open_g;
  assign open_g = ~(gate_a_i | gate_b_i);

  AST_TAP_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(tap_a_o) == 1); // R5
  AST_TAP_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(tap_b_o) == 1); // R5
  AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (open_g && gain_en_i && gain_code_i <= TOP_IDX)
      |=> tap_a_o == (NUM_TAPS'(1) << $past(gain_code_i))); // R2
  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gate_a_i || gate_b_i) |=> ($stable(tap_a_o) && $stable(tap_b_o) && $stable(code_over_o))); // R3
  AST_UNITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (open_g && !gain_en_i) |=> (tap_a_o[0] && tap_b_o[0] && !code_over_o)); // R4
  AST_WIDE_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    wide_bw_a_o == (|tap_a_o[NUM_TAPS-1:WIDE_TAP])); // R6
  AST_WIDE_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    wide_bw_b_o == (|tap_b_o[NUM_TAPS-1:WIDE_TAP])); // R6
  AST_OVER_AT_TOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    code_over_o |-> tap_a_o[NUM_TAPS-1]); // R7
  AST_STAGE_B_MODE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!CASCADE || !tap_b_o[0]) |-> (tap_b_o[0] || tap_a_o[NUM_TAPS-1])); // R8
endmodule

bind pga_gain_ctrl pga_gain_ctrl_chk #(
  .CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS), .WIDE_TAP(WIDE_TAP), .CASCADE(CASCADE)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .gate_a_i    (gate_a_i),
  .gate_b_i    (gate_b_i),
  .gain_en_i   (gain_en_i),
  .gain_code_i (gain_code_i),
  .tap_a_o     (tap_a_o),
  .wide_bw_a_o (wide_bw_a_o),
  .tap_b_o     (tap_b_o),
  .wide_bw_b_o (wide_bw_b_o),
  .code_over_o (code_over_o)
);

// File: tb/pga_gain_ctrl_tb.sv
module pga_gain_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       gate_a, gate_b, en;
  logic [2:0] code;
  logic [4:0] s_tap_a, s_tap_b, c_tap_a, c_tap_b;
  logic       s_wa, s_wb, s_ov, c_wa, c_wb, c_ov;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pga_gain_ctrl #(.CASCADE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_a_i(gate_a), .gate_b_i(gate_b),
    .gain_en_i(en), .gain_code_i(code),
    .tap_a_o(s_tap_a), .wide_bw_a_o(s_wa), .tap_b_o(s_tap_b),
    .wide_bw_b_o(s_wb), .code_over_o(s_ov));

  pga_gain_ctrl #(.CASCADE(1'b1)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .gate_a_i(gate_a), .gate_b_i(gate_b),
    .gain_en_i(en), .gain_code_i(code),
    .tap_a_o(c_tap_a), .wide_bw_a_o(c_wa), .tap_b_o(c_tap_b),
    .wide_bw_b_o(c_wb), .code_over_o(c_ov));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outputs of both copies for a held enable/code (R4 R5 R6 R7 R8)
  task automatic expect_word(string req, logic e, logic [2:0] c);
    int sa, ca, cb;
    sa = !e ? 0 : (c > 4 ? 4 : int'(c));
    ca = sa;
    cb = (e && c > 4) ? int'(c) - 4 : 0;
    check({req, " single tap_a"}, 16'(s_tap_a), 16'(5'(1) << sa));
    check({req, " single wide_a"}, 16'(s_wa), 16'(sa >= 3));
    check({req, " single stage b R7"}, 16'({s_tap_b, s_wb}), 16'({5'b00001, 1'b0}));
    check({req, " single over R7"}, 16'(s_ov), 16'(e && c > 4));
    check({req, " cascade tap_a R8"}, 16'(c_tap_a), 16'(5'(1) << ca));
    check({req, " cascade tap_b R8"}, 16'(c_tap_b), 16'(5'(1) << cb));
    check({req, " cascade wide R6"}, 16'({c_wa, c_wb}), 16'({ca >= 3, cb >= 3}));
    check({req, " cascade over R8"}, 16'(c_ov), 16'h0);
  endtask

  // Drive at negedge; outputs settle after the next posedge; sample at following negedge
  task automatic drive(logic ga, logic gb, logic e, logic [2:0] c);
    @(negedge clk);
    gate_a = ga; gate_b = gb; en = e; code = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; gate_a = 0; gate_b = 0; en = 1; code = 3'd4;
    repeat (3) @(negedge clk);
    check("R1 tap_a in reset", 16'({s_tap_a, c_tap_a}), 16'({5'b00001, 5'b00001}));
    check("R1 tap_b in reset", 16'({s_tap_b, c_tap_b}), 16'({5'b00001, 5'b00001}));
    check("R1 flags in reset", 16'({s_wa, s_wb, s_ov, c_wa, c_wb, c_ov}), 16'h0);
    gate_a = 1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release, gated", 16'({s_tap_a, c_tap_b, s_ov}), 16'({5'b00001, 5'b00001, 1'b0}));
    gate_a = 0;
  endtask

  task automatic t_sweep();
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 8; c++) begin
        drive(0, 0, e[0], c[2:0]);
        expect_word(e ? "R2 R5 sweep" : "R4 disabled", e[0], c[2:0]);
      end
  endtask

  task automatic t_hold_one(bit use_b);
    drive(0, 0, 1, 3'd2);
    expect_word("R2 preload", 1, 3'd2);
    drive(!use_b, use_b, 1, 3'd7);
    expect_word("R3 single gate holds", 1, 3'd2);
    drive(!use_b, use_b, 0, 3'd6);
    expect_word("R3 still held", 1, 3'd2);
    drive(1, 1, 1, 3'd5);
    expect_word("R3 both gates hold", 1, 3'd2);
    drive(use_b, !use_b, 1, 3'd5);
    expect_word("R3 other gate holds", 1, 3'd2);
    drive(0, 0, 1, 3'd5);
    expect_word("R3 release loads", 1, 3'd5);
  endtask

  task automatic t_cascade_sum();
    for (int c = 0; c < 8; c++) begin
      int ia, ib;
      drive(0, 0, 1, c[2:0]);
      ia = 0; ib = 0;
      for (int i = 0; i < 5; i++) begin
        if (c_tap_a[i]) ia = i;
        if (c_tap_b[i]) ib = i;
      end
      check("R8 gain sum", 16'(ia + ib), 16'(c));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_hold_one(1'b0);
    t_hold_one(1'b1);
    t_cascade_sum();
    drive(0, 0, 1, 3'd3);
    expect_word("R6 gain 8", 1, 3'd3);
    drive(0, 0, 0, 3'd3);
    expect_word("R4 disable after gain 8", 0, 3'd3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule